// File: doc/BRIEF.md
# Idle-Mode Timer and Wake Controller

This block keeps a free-running interval timer that advances once per instruction cycle. It also runs the small power-mode sequencer that stops the CPU core's clock. Software picks one of several power-of-two windows. Each time the counter completes the chosen window, a sticky pending flag is raised, and an interrupt follows if it is enabled. The timer never stops for idle, so the window events also serve as a time base during normal running.

Software writes a mode-control register to put the core to sleep. In idle, the core clock-enable is held low until the next window event, an external wake-up pulse, or reset. A second mode bit requests halt, a deeper sleep in which the timer is frozen and only the wake input or reset ends the sleep. A configuration input can veto halt requests altogether.

Registers are written through a one-cycle write strobe with an address:

- Address 0 selects the window.
- Address 1 holds the pending flag and the interrupt enable.
- Address 2 is the mode control.

Top module: `idle_wake_ctrl`

## Requirements
- R1: The 16-bit timer advances by one on every clock with `cyc_en_i` high, whether idle or not. It holds its value only while halted.
- R2: Window code `wr_data_i[2:0]`, written at address 0, gives the event spacing. Codes 0, 1, 2, 3 and 4 give 4096, 8192, 16384, 32768 and 65536 counted cycles. Codes 5 to 7 act as code 4. Events fall where the count from zero reaches a multiple of the window.
- R3: A window event sets `pend_o` on the clock edge that completes the window. `pend_o` then stays high until a write to address 1 with bit 0 = 0. A write with bit 0 = 1 leaves it alone. An event and a clearing write at the same edge leave it set.
- R4: `irq_o` is high exactly when `pend_o` is high and the enable bit (address 1, bit 1) is 1.
- R5: A write to address 2 with bit 6 = 1 sets `idle_o` and drops `cpu_clk_en_o` at that edge. `cpu_clk_en_o` stays low for as long as `idle_o` is high.
- R6: A window event while idle clears `idle_o` and raises `cpu_clk_en_o` at the edge of that event.
- R7: A high `wake_i` while idle clears `idle_o` and raises `cpu_clk_en_o` at the next edge.
- R8: Reset is synchronous and active high. It clears idle, halt, pending, enable and the window code (code 0), and sets `cpu_clk_en_o`. It ends an idle period at once.
- R9: A write to address 2 with bit 7 = 1 sets `halt_o` and drops `cpu_clk_en_o`, unless `halt_dis_i` is 1, in which case the write has no effect. Halt ends only by `wake_i` or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_en_i | input | 1 | Instruction-cycle strobe that advances the timer |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address: 0 window, 1 interrupt, 2 mode |
| wr_data_i | input | 8 | Register write data |
| wake_i | input | 1 | External wake-up request |
| halt_dis_i | input | 1 | Configuration option that disables halt |
| idle_o | output | 1 | Idle state (self-clearing idle control bit) |
| halt_o | output | 1 | Halt state |
| cpu_clk_en_o | output | 1 | Clock enable for the CPU core |
| pend_o | output | 1 | Window pending flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The properties assume that `rst` is a clean synchronous level and that `wake_i` is already free of glitches. They also assume idle and halt are only requested through the mode register, never both in a way that overlaps a running sleep. The bench drives every input half a cycle away from the sampling edge. It keeps `cyc_en_i` high so that event edges can be predicted from the reset point. It asserts wake and write strobes for exactly one cycle each, and it issues halt and idle requests only while the core is awake.

// File: rtl/iw_pkg.sv
package iw_pkg;
  localparam int CNT_W    = 16;
  localparam int TAP_BASE = 12;
  localparam int N_TAPS   = 5;
  localparam int SEL_W    = 3;
  localparam int DATA_W   = 8;
  localparam int ADDR_W   = 2;
  localparam int PND_BIT  = 0;
  localparam int IE_BIT   = 1;
  localparam int IDLE_BIT = 6;
  localparam int HALT_BIT = 7;

  typedef enum logic [ADDR_W-1:0] {
    REG_WIN  = 2'd0,
    REG_INT  = 2'd1,
    REG_MODE = 2'd2
  } reg_addr_e;
endpackage

// File: rtl/iw_idle_timer.sv
module iw_idle_timer #(
  parameter int CNT_W    = 16,
  parameter int TAP_BASE = 12,
  parameter int N_TAPS   = 5,
  parameter int SEL_W    = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic [SEL_W-1:0] sel,
  output logic             win_evt
);
  localparam int TOP_TAP = TAP_BASE + N_TAPS - 1;
  localparam logic [SEL_W-1:0] SEL_MAX = SEL_W'(N_TAPS - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [N_TAPS-1:0] tap_evt;
  logic [SEL_W-1:0]  sel_eff;

  initial begin
    if (TOP_TAP != CNT_W) $error("top tap must be the counter carry-out");
  end

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (step) cnt_q <= cnt_q + 1'b1;
  end

  // tap k toggles on the step where all lower bits are ones
  for (genvar i = 0; i < N_TAPS; i++) begin : g_tap
    assign tap_evt[i] = step & (&cnt_q[TAP_BASE+i-1:0]);
  end

  always_comb begin
    sel_eff = (sel > SEL_MAX) ? SEL_MAX : sel;
    win_evt = tap_evt[sel_eff];
  end
endmodule

// File: rtl/iw_irq_ctrl.sv
module iw_irq_ctrl #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             win_wr,
  input  logic [SEL_W-1:0] win_data,
  input  logic             int_wr,
  input  logic             pnd_val,
  input  logic             ie_val,
  input  logic             win_evt,
  output logic [SEL_W-1:0] sel_o,
  output logic             pend_o,
  output logic             irq_o
);
  logic pend_next, ie_next, ie_q;

  always_comb begin
    pend_next = win_evt | (pend_o & ~(int_wr & ~pnd_val));
    ie_next   = int_wr ? ie_val : ie_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_o  <= '0;
      pend_o <= 1'b0;
      ie_q   <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      if (win_wr) sel_o <= win_data;
      pend_o <= pend_next;
      ie_q   <= ie_next;
      irq_o  <= pend_next & ie_next;
    end
  end
endmodule

// File: rtl/iw_mode_ctrl.sv
module iw_mode_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic mode_wr,
  input  logic idle_req,
  input  logic halt_req,
  input  logic halt_dis,
  input  logic wake,
  input  logic win_evt,
  output logic idle_o,
  output logic halt_o,
  output logic clk_en_o
);
  logic awake, halt_take, idle_take;
  logic idle_next, halt_next;

  always_comb begin
    awake     = ~idle_o & ~halt_o;
    halt_take = awake & mode_wr & halt_req & ~halt_dis;
    idle_take = awake & mode_wr & idle_req & ~halt_take & ~win_evt;
    idle_next = idle_o ? ~(win_evt | wake) : idle_take;
    halt_next = halt_o ? ~wake : halt_take;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idle_o   <= 1'b0;
      halt_o   <= 1'b0;
      clk_en_o <= 1'b1;
    end else begin
      idle_o   <= idle_next;
      halt_o   <= halt_next;
      clk_en_o <= ~(idle_next | halt_next);
    end
  end
endmodule

// File: rtl/idle_wake_ctrl.sv
module idle_wake_ctrl
  import iw_pkg::*;
#(
  parameter int CNT_W    = iw_pkg::CNT_W,
  parameter int TAP_BASE = iw_pkg::TAP_BASE,
  parameter int N_TAPS   = iw_pkg::N_TAPS,
  parameter int SEL_W    = iw_pkg::SEL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cyc_en_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              wake_i,
  input  logic              halt_dis_i,
  output logic              idle_o,
  output logic              halt_o,
  output logic              cpu_clk_en_o,
  output logic              pend_o,
  output logic              irq_o
);
  logic             win_wr, int_wr, mode_wr;
  logic             step, win_evt;
  logic [SEL_W-1:0] sel_q;
  logic             unused_data_bits;

  assign win_wr  = wr_en_i & (wr_addr_i == REG_WIN);
  assign int_wr  = wr_en_i & (wr_addr_i == REG_INT);
  assign mode_wr = wr_en_i & (wr_addr_i == REG_MODE);
  assign step    = cyc_en_i & ~halt_o;
  assign unused_data_bits = ^wr_data_i[5:SEL_W];

  iw_idle_timer #(
    .CNT_W(CNT_W), .TAP_BASE(TAP_BASE), .N_TAPS(N_TAPS), .SEL_W(SEL_W)
  ) u_timer (
    .clk(clk), .rst(rst), .step(step), .sel(sel_q), .win_evt(win_evt)
  );

  iw_irq_ctrl #(.SEL_W(SEL_W)) u_irq (
    .clk(clk), .rst(rst),
    .win_wr(win_wr), .win_data(wr_data_i[SEL_W-1:0]),
    .int_wr(int_wr), .pnd_val(wr_data_i[PND_BIT]), .ie_val(wr_data_i[IE_BIT]),
    .win_evt(win_evt), .sel_o(sel_q), .pend_o(pend_o), .irq_o(irq_o)
  );

  iw_mode_ctrl u_mode (
    .clk(clk), .rst(rst), .mode_wr(mode_wr),
    .idle_req(wr_data_i[IDLE_BIT]), .halt_req(wr_data_i[HALT_BIT]),
    .halt_dis(halt_dis_i), .wake(wake_i), .win_evt(win_evt),
    .idle_o(idle_o), .halt_o(halt_o), .clk_en_o(cpu_clk_en_o)
  );
endmodule

// File: rtl/iw_checker.sv
module iw_checker
  import iw_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              wake_i,
  input logic              halt_dis_i,
  input logic              idle_o,
  input logic              halt_o,
  input logic              cpu_clk_en_o,
  input logic              pend_o,
  input logic              irq_o,
  input logic              win_evt
);
  logic clr_wr;
  logic unused_chk_bits;
  assign clr_wr = wr_en_i && (wr_addr_i == REG_INT) && !wr_data_i[PND_BIT];
  assign unused_chk_bits = ^wr_data_i[DATA_W-1:1];

  AST_CLKEN_LOW_IN_IDLE: assert property (@(posedge clk) disable iff (rst)
    idle_o |-> !cpu_clk_en_o); // R5
  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (rst)
    (pend_o && !clr_wr) |=> pend_o); // R3
  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> pend_o); // R4
  AST_TIMER_EXIT: assert property (@(posedge clk) disable iff (rst)
    (idle_o && win_evt) |=> (!idle_o && cpu_clk_en_o)); // R6
  AST_WAKE_EXIT: assert property (@(posedge clk) disable iff (rst)
    (idle_o && wake_i) |=> (!idle_o && cpu_clk_en_o)); // R7
  AST_HALT_VETO: assert property (@(posedge clk) disable iff (rst)
    (!halt_o && halt_dis_i) |=> !halt_o); // R9
  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (!idle_o && !halt_o && !pend_o && !irq_o && cpu_clk_en_o)); // R8
endmodule

bind idle_wake_ctrl iw_checker u_chk (
  .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
  .wr_data_i(wr_data_i), .wake_i(wake_i), .halt_dis_i(halt_dis_i),
  .idle_o(idle_o), .halt_o(halt_o), .cpu_clk_en_o(cpu_clk_en_o),
  .pend_o(pend_o), .irq_o(irq_o), .win_evt(win_evt)
);

// File: tb/idle_wake_ctrl_bench.sv
module idle_wake_ctrl_bench;
  logic       clk = 1'b0, rst = 1'b1, cyc_en = 1'b1, wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       wake = 1'b0, hdis = 1'b0;
  logic       idle, halt, clk_en, pend, irq;

  idle_wake_ctrl u_idle_wake_ctrl (
    .clk(clk), .rst(rst), .cyc_en_i(cyc_en), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .wake_i(wake),
    .halt_dis_i(hdis), .idle_o(idle), .halt_o(halt),
    .cpu_clk_en_o(clk_en), .pend_o(pend), .irq_o(irq)
  );

  always #5 clk = ~clk;

  int cyc;
  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  int n_run = 0, n_fail = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b0; wake = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic wait_rise(output int t, input int limit);
    while (!pend && cyc < limit) @(negedge clk);
    t = cyc;
  endtask

  task automatic t_reset();
    do_reset();
    check(!idle,  "R8", "idle after reset", idle, 0);
    check(!halt,  "R8", "halt after reset", halt, 0);
    check(!pend,  "R8", "pend after reset", pend, 0);
    check(!irq,   "R8", "irq after reset", irq, 0);
    check(clk_en, "R8", "clk_en after reset", clk_en, 1);
  endtask

  task automatic t_windows();
    int codes [6] = '{0, 1, 2, 3, 4, 7};
    int exps  [6] = '{4096, 8192, 16384, 32768, 65536, 131072};
    int t;
    do_reset();
    for (int k = 0; k < 6; k++) begin
      if (k > 0) begin
        wr(2'd1, 8'h00);
        check(!pend, "R3", "pend after clear", pend, 0);
        wr(2'd0, 8'(codes[k]));
      end
      wait_rise(t, exps[k] + 10);
      check(t == exps[k], "R2", $sformatf("event edge for code %0d", codes[k]), t, exps[k]);
      check(!irq, "R4", "irq with enable off", irq, 0);
    end
  endtask

  task automatic t_idle_timer();
    do_reset();
    wr(2'd1, 8'h02);
    wr(2'd2, 8'h40);
    check(idle && !clk_en, "R5", "idle entered, clk_en low", {idle, clk_en}, 2);
    wait_cyc(2000);
    check(idle && !clk_en, "R5", "still idle mid-window", {idle, clk_en}, 2);
    wait_cyc(4095);
    wr(2'd1, 8'h02);
    check(pend, "R3", "event wins over clear", pend, 1);
    check(irq,  "R4", "irq with enable on", irq, 1);
    check(!idle && clk_en, "R6", "timer wake at edge 4096", {idle, clk_en}, 1);
    check(cyc == 4096, "R1", "timer ran during idle", cyc, 4096);
    wr(2'd1, 8'h03);
    check(pend, "R3", "write of 1 keeps pend", pend, 1);
    wr(2'd1, 8'h02);
    check(!pend && !irq, "R3", "write of 0 clears", {pend, irq}, 0);
  endtask

  task automatic t_idle_wake();
    do_reset();
    wr(2'd2, 8'h40);
    repeat (20) @(negedge clk);
    check(idle, "R7", "idle before wake", idle, 1);
    wake = 1'b1;
    @(negedge clk);
    wake = 1'b0;
    check(!idle && clk_en, "R7", "external wake exit", {idle, clk_en}, 1);
    check(!pend, "R7", "no timer event on wake", pend, 0);
  endtask

  task automatic t_idle_reset();
    do_reset();
    wr(2'd2, 8'h40);
    check(idle, "R8", "idle before reset", idle, 1);
    rst = 1'b1;
    @(negedge clk);
    check(!idle && clk_en, "R8", "reset ends idle", {idle, clk_en}, 1);
    rst = 1'b0;
  endtask

  task automatic t_halt();
    int t;
    do_reset();
    hdis = 1'b1;
    wr(2'd2, 8'h80);
    check(!halt && clk_en, "R9", "halt vetoed", {halt, clk_en}, 1);
    do_reset();
    hdis = 1'b0;
    wait_cyc(10);
    wr(2'd2, 8'h80);
    check(halt && !clk_en, "R9", "halt entered", {halt, clk_en}, 2);
    wait_cyc(210);
    wake = 1'b1;
    @(negedge clk);
    wake = 1'b0;
    check(!halt && clk_en, "R9", "wake ends halt", {halt, clk_en}, 1);
    wait_rise(t, 4306);
    check(t == 4296, "R1", "timer frozen during halt", t, 4296);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_windows();
    t_idle_timer();
    t_idle_wake();
    t_idle_reset();
    t_halt();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule